// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block chooses which of four sources drives the system clock: the crystal at 32 MHz, the RC oscillator at 32 MHz, the low-power clock, or a 64 MHz doubler fed from the crystal. Software writes a source code into a select field. The block checks the request against the switching rules and then runs a handshake with the chosen source. It publishes the live source as a set of one-hot running flags, which software polls until the flag for its target comes up. Moving from RC to crystal does not use the select field. It has its own trigger bit.

The block also owns the doubler's control-logic reset and enable. It refuses to turn the doubler off while the doubler is the live source or the pending target. The oscillators are modelled as ready inputs. Glitch-free multiplexing of the clocks themselves belongs to a neighbouring block, which consumes `cur_src`. Every interface is a plain control or status pin, and none of them applies back-pressure.

A request that breaks a rule changes nothing except the sticky error flag. The same holds for a request that arrives while a switch is still pending.

Top module: `sysclk_switch_ctrl`

## Requirements
- R1: Select codes are 0 = crystal, 1 = RC, 2 = low-power, 3 = doubler. Any code from 4 to 7 is rejected: the source does not change and `req_err` goes high.
- R2: `run_flags` bit 0 = low-power, bit 1 = RC, bit 2 = crystal, bit 3 = doubler, and at most one bit is ever high. `run_flags[3:1]` therefore reads 000 for low-power, 001 for RC, 010 for crystal and 100 for doubler. After reset the source is RC (`run_flags` = 0010, `cur_src` = 1).
- R3: A doubler request is accepted only when the live source is the crystal or the doubler.
- R4: A doubler request is accepted only when both `hclk_div` and `pclk_div` are 0 (divide by one).
- R5: While the doubler is live, only crystal and doubler requests are accepted.
- R6: The RC-to-crystal move is made only by `xtal_trig`. A select-field request for the crystal from RC is rejected, and so is `xtal_trig` when the live source is not RC. When `xtal_trig` and `sel_wr` are high in the same cycle, the trigger is taken and the select write is dropped.
- R7: An accepted request raises `busy` on the next edge. The running flags keep the old source until the target's ready input is seen high. The flags then move on that edge and `busy` falls on the same edge. A request made while `busy` is high is ignored and sets `req_err`.
- R8: `dblr_on` releases `dblr_rst_n` on the next edge, and `dblr_en` rises one edge after that. `dblr_off` drops both signals on the next edge. `dblr_off` is refused, with `req_err` set, while the doubler is live or is the pending target.
- R9: `dblr_out_rdy` is high exactly when the doubler is enabled and its ready input is high. A doubler switch completes only when this signal is high.
- R10: `req_err` is sticky and is cleared by a pulse on `err_clr`. When a new error and a clear arrive in the same cycle, the error wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_wr | input | 1 | Pulse: write to the select field |
| sel_val | input | SEL_W (3) | Requested source code |
| xtal_trig | input | 1 | Pulse: RC-to-crystal trigger |
| hclk_div | input | HDIV_W (3) | High-speed bus divider code, 0 means divide by one |
| pclk_div | input | PDIV_W (2) | Peripheral bus divider code, 0 means divide by one |
| src_ready | input | 4 | Ready input of each source, indexed by select code |
| dblr_on | input | 1 | Pulse: start the doubler |
| dblr_off | input | 1 | Pulse: stop the doubler |
| err_clr | input | 1 | Pulse: clear `req_err` |
| run_flags | output | 4 | One-hot running flags {doubler, crystal, RC, low-power} |
| cur_src | output | 2 | Code of the live source, for the clock multiplexer |
| busy | output | 1 | A switch is pending |
| dblr_rst_n | output | 1 | Doubler control-logic reset, active low |
| dblr_en | output | 1 | Doubler enable |
| dblr_out_rdy | output | 1 | Doubler output is usable |
| req_err | output | 1 | Sticky error for a rejected request |

## Verification
The hardest states to reach are those whose starting source is the doubler, because getting there needs a legal chain of three steps. The bench resets before every case. It starts the doubler, fires the crystal trigger and then selects the doubler with both dividers at one. Only after that does it apply the request under test. A second hard case is a request that lands while a switch is pending. The bench holds one source's ready input low so that `busy` stays high, fires a trigger into that window, and then releases the ready input to confirm that the original target still wins.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  typedef enum logic [1:0] {
    SRC_XTAL = 2'd0,
    SRC_RC   = 2'd1,
    SRC_LP   = 2'd2,
    SRC_DBLR = 2'd3
  } src_e;

  localparam int NSRC = 4;

  // position of each source inside the running-flag vector
  function automatic int flag_pos(input src_e s);
    case (s)
      SRC_LP:   flag_pos = 0;
      SRC_RC:   flag_pos = 1;
      SRC_XTAL: flag_pos = 2;
      default:  flag_pos = 3;
    endcase
  endfunction
endpackage

// File: rtl/sysclk_req_check.sv
module sysclk_req_check
  import sysclk_pkg::*;
#(
  parameter int SEL_W  = 3,
  parameter int HDIV_W = 3,
  parameter int PDIV_W = 2
) (
  input  logic [SEL_W-1:0]  sel_val,
  input  logic              use_trig,
  input  src_e              cur,
  input  logic [HDIV_W-1:0] hclk_div,
  input  logic [PDIV_W-1:0] pclk_div,
  output logic              legal,
  output src_e              tgt
);
  logic out_of_range;
  logic divs_unity;

  assign out_of_range = (sel_val >> 2) != '0;
  assign divs_unity   = (hclk_div == '0) && (pclk_div == '0);

  always_comb begin
    legal = 1'b1;
    tgt   = SRC_XTAL;
    if (use_trig) begin
      legal = (cur == SRC_RC);
    end else if (out_of_range) begin
      legal = 1'b0;
    end else begin
      tgt = src_e'(sel_val[1:0]);
      if (tgt == SRC_DBLR && !(cur == SRC_XTAL || cur == SRC_DBLR)) legal = 1'b0;
      if (tgt == SRC_DBLR && !divs_unity) legal = 1'b0;
      if (cur == SRC_DBLR && !(tgt == SRC_XTAL || tgt == SRC_DBLR)) legal = 1'b0;
      if (tgt == SRC_XTAL && cur == SRC_RC) legal = 1'b0;
    end
  end
endmodule

// File: rtl/sysclk_seq.sv
module sysclk_seq
  import sysclk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_any,
  input  logic            legal,
  input  src_e            tgt_in,
  input  logic [NSRC-1:0] eff_ready,
  input  logic            dblr_refuse,
  input  logic            err_clr,
  output src_e            cur,
  output src_e            tgt,
  output logic            busy,
  output logic [NSRC-1:0] run_flags,
  output logic            err
);
  src_e            cur_q, tgt_q;
  logic            busy_q, err_q;
  logic [NSRC-1:0] run_q;
  logic            accept, finish, err_set;

  assign accept  = !busy_q && req_any && legal;
  assign finish  = busy_q && eff_ready[tgt_q];
  assign err_set = (req_any && (busy_q || !legal)) || dblr_refuse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= SRC_RC;
      tgt_q  <= SRC_RC;
      busy_q <= 1'b0;
      run_q  <= NSRC'(1) << flag_pos(SRC_RC);
    end else if (accept) begin
      busy_q <= 1'b1;
      tgt_q  <= tgt_in;
    end else if (finish) begin
      busy_q <= 1'b0;
      cur_q  <= tgt_q;
      run_q  <= NSRC'(1) << flag_pos(tgt_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
    else if (err_clr) err_q <= 1'b0;
  end

  assign cur       = cur_q;
  assign tgt       = tgt_q;
  assign busy      = busy_q;
  assign run_flags = run_q;
  assign err       = err_q;

  assert_flags_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(run_flags));
  assert_flags_hold_until_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !eff_ready[tgt_q] |=> $stable(run_flags) && busy_q);
  assert_reject_sets_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_any && !legal |=> err_q);
endmodule

// File: rtl/sysclk_dblr_ctl.sv
module sysclk_dblr_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic on_req,
  input  logic off_req,
  input  logic live,
  output logic dblr_rst_n,
  output logic dblr_en,
  output logic refuse
);
  typedef enum logic [1:0] {D_OFF, D_RLS, D_ON} dstate_e;
  dstate_e st_q;

  assign refuse = off_req && live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= D_OFF;
    else if (off_req) begin
      if (!live) st_q <= D_OFF;
    end else if (on_req && st_q == D_OFF) st_q <= D_RLS;
    else if (st_q == D_RLS) st_q <= D_ON;
  end

  assign dblr_rst_n = (st_q != D_OFF);
  assign dblr_en    = (st_q == D_ON);

  assert_enable_after_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dblr_en) |-> $past(dblr_rst_n));
  assert_refused_off_keeps_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    refuse && dblr_en |=> dblr_en);
endmodule

// File: rtl/sysclk_switch_ctrl.sv
module sysclk_switch_ctrl
  import sysclk_pkg::*;
#(
  parameter int SEL_W  = 3,
  parameter int HDIV_W = 3,
  parameter int PDIV_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr,
  input  logic [SEL_W-1:0]  sel_val,
  input  logic              xtal_trig,
  input  logic [HDIV_W-1:0] hclk_div,
  input  logic [PDIV_W-1:0] pclk_div,
  input  logic [3:0]        src_ready,
  input  logic              dblr_on,
  input  logic              dblr_off,
  input  logic              err_clr,
  output logic [3:0]        run_flags,
  output logic [1:0]        cur_src,
  output logic              busy,
  output logic              dblr_rst_n,
  output logic              dblr_en,
  output logic              dblr_out_rdy,
  output logic              req_err
);
  src_e            cur, tgt_pend, tgt_chk;
  logic            legal, refuse, live;
  logic [NSRC-1:0] eff_ready;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_ready
      if (i == int'(SRC_DBLR)) begin : g_dblr
        assign eff_ready[i] = src_ready[i] & dblr_en;
      end else begin : g_plain
        assign eff_ready[i] = src_ready[i];
      end
    end
  endgenerate

  sysclk_req_check #(.SEL_W(SEL_W), .HDIV_W(HDIV_W), .PDIV_W(PDIV_W)) u_chk (
    .sel_val(sel_val), .use_trig(xtal_trig), .cur(cur),
    .hclk_div(hclk_div), .pclk_div(pclk_div), .legal(legal), .tgt(tgt_chk)
  );

  sysclk_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_any(sel_wr | xtal_trig), .legal(legal),
    .tgt_in(tgt_chk), .eff_ready(eff_ready), .dblr_refuse(refuse),
    .err_clr(err_clr), .cur(cur), .tgt(tgt_pend), .busy(busy),
    .run_flags(run_flags), .err(req_err)
  );

  assign live = (cur == SRC_DBLR) || (busy && tgt_pend == SRC_DBLR);

  sysclk_dblr_ctl u_dblr (
    .clk(clk), .rst_n(rst_n), .on_req(dblr_on), .off_req(dblr_off), .live(live),
    .dblr_rst_n(dblr_rst_n), .dblr_en(dblr_en), .refuse(refuse)
  );

  assign cur_src      = cur;
  assign dblr_out_rdy = eff_ready[SRC_DBLR];

  assert_dblr_live_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_flags[3] |-> dblr_en);
  assert_dblr_entry_from_xtal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_flags[3]) |-> $past(run_flags[2]));
endmodule

// File: tb/sysclk_switch_ctrl_tb.sv
module sysclk_switch_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_wr = 1'b0, xtal_trig = 1'b0, dblr_on = 1'b0, dblr_off = 1'b0, err_clr = 1'b0;
  logic [2:0] sel_val = '0, hclk_div = '0;
  logic [1:0] pclk_div = '0;
  logic [3:0] src_ready = 4'hF;
  logic [3:0] run_flags;
  logic [1:0] cur_src;
  logic       busy, dblr_rst_n, dblr_en, dblr_out_rdy, req_err;

  int checks = 0, fails = 0, cycles = 0;

  always #2 clk = ~clk;

  sysclk_switch_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_val(sel_val), .xtal_trig(xtal_trig),
    .hclk_div(hclk_div), .pclk_div(pclk_div), .src_ready(src_ready), .dblr_on(dblr_on),
    .dblr_off(dblr_off), .err_clr(err_clr), .run_flags(run_flags), .cur_src(cur_src),
    .busy(busy), .dblr_rst_n(dblr_rst_n), .dblr_en(dblr_en), .dblr_out_rdy(dblr_out_rdy),
    .req_err(req_err)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [3:0] flags_of(input int s);
    int p;
    p = (s == 2) ? 0 : (s == 1) ? 1 : (s == 0) ? 2 : 3;
    return 4'(1 << p);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 50 && busy; n++) @(negedge clk);
  endtask

  task automatic do_sel(input int v);
    sel_val = 3'(v);
    pulse(sel_wr);
    wait_idle();
  endtask

  task automatic do_trig();
    pulse(xtal_trig);
    wait_idle();
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    hclk_div = '0; pclk_div = '0; src_ready = 4'hF;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic goto_src(input int s);
    do_reset();
    pulse(dblr_on);
    @(negedge clk);
    if (s == 2) do_sel(2);
    if (s == 0 || s == 3) do_trig();
    if (s == 3) do_sel(3);
    pulse(err_clr);
  endtask

  function automatic bit legal_of(input int cur, input int sel, input int divs);
    if (sel > 3) return 0;
    if (sel == 3 && !(cur == 0 || cur == 3)) return 0;
    if (sel == 3 && divs != 0) return 0;
    if (cur == 3 && !(sel == 0 || sel == 3)) return 0;
    if (sel == 0 && cur == 1) return 0;
    return 1;
  endfunction

  initial begin
    do_reset();
    chk("R2 reset flags", run_flags, 4'b0010);
    chk("R2 reset cur_src", cur_src, 1);
    chk("R10 reset err", req_err, 0);
    chk("R8 reset dblr_rst_n", dblr_rst_n, 0);
    chk("R9 ready while disabled", dblr_out_rdy, 0);

    // R8 enable sequencing
    pulse(dblr_on);
    chk("R8 release first", {dblr_rst_n, dblr_en}, 2'b10);
    @(negedge clk);
    chk("R8 enable second", {dblr_rst_n, dblr_en}, 2'b11);
    chk("R9 ready when enabled", dblr_out_rdy, 1);

    // R1 R3 R4 R5 sweep over start source x code x divider pattern
    for (int st = 0; st < 4; st++)
      for (int sv = 0; sv < 8; sv++)
        for (int dp = 0; dp < 4; dp++) begin
          bit lg;
          int exp_src;
          goto_src(st);
          chk("R2 start flags", run_flags, flags_of(st));
          hclk_div = dp[0] ? 3'd2 : 3'd0;
          pclk_div = dp[1] ? 2'd1 : 2'd0;
          lg = legal_of(st, sv, dp);
          exp_src = lg ? sv : st;
          do_sel(sv);
          chk(sv > 3 ? "R1 range" : (sv == 3 ? "R3 R4 doubler entry" :
              (st == 3 ? "R5 doubler exit" : "R6 select")), run_flags, flags_of(exp_src));
          chk("R2 cur_src", cur_src, exp_src);
          chk("R10 err", req_err, lg ? 0 : 1);
        end

    // R6 trigger from every source
    for (int st = 0; st < 4; st++) begin
      goto_src(st);
      do_trig();
      chk("R6 trigger", run_flags, flags_of(st == 1 ? 0 : st));
      chk("R6 trigger err", req_err, st == 1 ? 0 : 1);
    end

    // R6 trigger wins over a simultaneous select write
    goto_src(1);
    @(negedge clk); sel_val = 3'd2; sel_wr = 1'b1; xtal_trig = 1'b1;
    @(negedge clk); sel_wr = 1'b0; xtal_trig = 1'b0;
    wait_idle();
    chk("R6 trigger priority", run_flags, flags_of(0));

    // R7 wait on ready, request during busy ignored
    goto_src(1);
    src_ready[2] = 1'b0;
    sel_val = 3'd2;
    pulse(sel_wr);
    chk("R7 busy raised", busy, 1);
    for (int n = 0; n < 5; n++) @(negedge clk);
    chk("R7 flags held", run_flags, 4'b0010);
    pulse(xtal_trig);
    chk("R7 busy request err", req_err, 1);
    chk("R7 still busy", busy, 1);
    src_ready[2] = 1'b1;
    @(negedge clk);
    chk("R7 switched after ready", run_flags, flags_of(2));
    chk("R7 busy cleared", busy, 0);

    // R10 clear
    pulse(err_clr);
    chk("R10 cleared", req_err, 0);

    // R8 off refused while live, accepted otherwise
    goto_src(3);
    pulse(dblr_off);
    chk("R8 refused off keeps enable", dblr_en, 1);
    chk("R8 refused off err", req_err, 1);
    do_sel(0);
    pulse(dblr_off);
    chk("R8 off drops both", {dblr_rst_n, dblr_en}, 2'b00);
    chk("R9 ready after off", dblr_out_rdy, 0);

    // R9 doubler switch waits for enable
    do_sel(3);
    for (int n = 0; n < 4; n++) @(negedge clk);
    chk("R9 no switch without enable", run_flags, flags_of(0));
    pulse(dblr_on);
    @(negedge clk); @(negedge clk);
    chk("R9 switch after enable", run_flags, flags_of(3));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule